// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Port

This block is the slave side of the four-wire serial link of a low-rate converter. A host drives a serial clock, an active-low select and a data input, and receives bits on one pin that carries both the shifted-out data and an active-low result-ready level. Each exchange opens with an 8-bit command byte, MSB first, that names a register and a direction. The port then shifts out the status, mode or result word, or shifts in a new mode byte. After that it waits for the next command byte.

The stored values and the ready flag belong to a companion conversion controller. The port reads them from plain input buses. It reports a mode write, a completed result read and a resynchronising reset as single-cycle strobes. The serial pins are sampled by the system clock through two-flop synchronisers. The serial clock idles high: output bits move on its falling edge, and input bits are taken on its rising edge. The pad's three-state control is brought out as `dout_oe`.

A continuous-read mode streams each new result with no command byte. A run of 32 ones on the data input brings the port back to its default state from any mode.

Top module: `sd_serial_port`

## Requirements
- R1: After reset the port waits for a command byte, `chan` is 0, and no strobe is active. With select low and no word being shifted, `dout` equals the inverse of `drdy`.
- R2: The command byte holds these fields: bit 7 is the enable bit and must be 0; bit 6 is ignored; bits 5:4 select the register; bit 3 is 1 for read; bit 2 requests continuous read; bits 1:0 are the channel. While the port waits for a byte, every leading 1 is dropped. The 7 bits that follow the first 0 complete the byte.
- R3: A read of register 00 (command 0x08) returns `stat_in` as 8 bits, MSB first. Each bit is presented at a serial clock falling edge and held through the next rising edge.
- R4: A read of register 01 (command 0x18) returns `mode_in` as 8 bits, MSB first.
- R5: A write of register 01 (command 0x10) followed by 8 bits pulses `mode_wr` for one cycle, with `mode_wdata` equal to those 8 bits, MSB first.
- R6: A read of register 11 (command 0x38) returns `data_in` as DATA_W bits, MSB first. `data_rd` pulses once after the last bit's rising edge.
- R7: Register 10 (reserved) in either direction, a write of register 11, and a write of register 00 shift no word and raise no strobe. The port goes back to waiting for a command byte.
- R8: `chan` takes bits 1:0 of every command byte accepted while the port is waiting for a command.
- R9: 32 consecutive rising edges with the data input high, with select low, pulse `dev_rst` and return the port to its reset state. This holds in every mode. Select going high holds the run count and does not clear it.
- R10: Command 0x3C enters continuous read. In that mode, each serial clock falling edge that finds `drdy` high and no word in progress starts shifting `data_in`. `data_rd` pulses after its last bit.
- R11: In continuous read, the byte 0x38 (pattern 001110xx) leaves the mode only if it is received while `drdy` is low. With `drdy` high, the clocks shift out a result instead.
- R12: Select going high aborts any partial byte or word, with no strobe. Outside continuous read, the port then waits for a command byte. In continuous read, it stays in that mode.
- R13: `dout_oe` is low while select is high and high while select is low, after the two-cycle synchroniser delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data out, or inverse of ready when idle |
| dout_oe | output | 1 | Pad output enable for dout |
| drdy | input | 1 | Controller has an unread result |
| stat_in | input | 8 | Status byte from controller |
| mode_in | input | 8 | Current mode byte from controller |
| data_in | input | DATA_W | Latest conversion result |
| mode_wr | output | 1 | One-cycle mode write strobe |
| mode_wdata | output | 8 | Mode byte written by host |
| data_rd | output | 1 | One-cycle strobe after a full result read |
| chan | output | 2 | Channel field of the last command |
| dev_rst | output | 1 | One-cycle resynchronising reset strobe |

## Verification
The assertions expect the host to hold `cs_n` high through reset. They also expect each serial clock phase to last several system clocks, so that the synchronisers see every edge and a strobe can never fall on two adjacent cycles. The bench drives every serial phase as six system clocks and keeps `cs_n` high during reset. It holds the data input low while words are read out, so the 32-ones count is reached only when a test intends it. Random status, mode and result values, random channel fields and random mode bytes are mixed with directed cases for enable-bit skipping, aborts, reserved registers, continuous-read exit gating and resynchronisation.

// File: rtl/sd_serial_port.sv
module sd_serial_port #(
  parameter int DATA_W      = 24,
  parameter int RESYNC_ONES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic              drdy,
  input  logic [7:0]        stat_in,
  input  logic [7:0]        mode_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              mode_wr,
  output logic [7:0]        mode_wdata,
  output logic              data_rd,
  output logic [1:0]        chan,
  output logic              dev_rst
);
  localparam int LEN_W = $clog2(DATA_W + 1);
  localparam int ONE_W = $clog2(RESYNC_ONES + 1);
  localparam logic [LEN_W-1:0] LAST_B = LEN_W'(7);
  localparam logic [LEN_W-1:0] LAST_D = LEN_W'(DATA_W - 1);

  typedef enum logic [1:0] {S_CMD, S_WMODE, S_READ, S_CREAD} st_t;

  st_t               st;
  logic              sclk_m, sclk_s, sclk_d, cs_m, cs_s, din_m, din_s;
  logic              wen_seen, active, is_data;
  logic [2:0]        cbits;
  logic [6:0]        cmd_sr;
  logic [7:0]        wsr;
  logic [LEN_W-1:0]  cnt, last;
  logic [DATA_W-1:0] out_sr;
  logic [ONE_W-1:0]  ones;

  wire rise    = sclk_s & ~sclk_d;
  wire fall    = ~sclk_s & sclk_d;
  wire resync  = rise & ~cs_s & din_s & (ones == ONE_W'(RESYNC_ONES - 1));
  wire [6:0] byte_w = {cmd_sr[5:0], din_s};
  wire byte_done = rise & wen_seen & (cbits == 3'd6);
  wire cmd_eng = (st == S_CMD) | ((st == S_CREAD) & ~active);

  assign dout    = active ? out_sr[DATA_W-1] : ~drdy;
  assign dout_oe = ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_d} <= 3'b111;
      {cs_m, cs_s}             <= 2'b11;
      {din_m, din_s}           <= 2'b00;
    end else begin
      {sclk_m, sclk_s, sclk_d} <= {sclk, sclk_m, sclk_s};
      {cs_m, cs_s}             <= {cs_n, cs_m};
      {din_m, din_s}           <= {din, din_m};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ones <= '0;
    else if (resync)              ones <= '0;
    else if (rise && !cs_s)       ones <= din_s ? ones + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; wen_seen <= 1'b0; active <= 1'b0; is_data <= 1'b0;
      cbits <= '0; cmd_sr <= '0; wsr <= '0; cnt <= '0; last <= '0;
      out_sr <= '0; mode_wr <= 1'b0; mode_wdata <= '0; data_rd <= 1'b0;
      chan <= '0; dev_rst <= 1'b0;
    end else begin
      mode_wr <= 1'b0;
      data_rd <= 1'b0;
      dev_rst <= 1'b0;
      if (cs_s) begin
        if (st != S_CREAD) st <= S_CMD;
        wen_seen <= 1'b0; cbits <= '0; cnt <= '0; active <= 1'b0;
      end else if (resync) begin
        st <= S_CMD; wen_seen <= 1'b0; active <= 1'b0; is_data <= 1'b0;
        cbits <= '0; cnt <= '0; chan <= '0; dev_rst <= 1'b1;
      end else begin
        if (cmd_eng && rise) begin
          if (!wen_seen) begin
            wen_seen <= ~din_s;
            cbits    <= '0;
          end else if (cbits != 3'd6) begin
            cmd_sr <= byte_w;
            cbits  <= cbits + 1'b1;
          end else begin
            wen_seen <= 1'b0;
          end
        end
        if (byte_done && st == S_CMD) begin
          chan <= byte_w[1:0];
          cnt  <= '0;
          if (byte_w[3]) begin
            unique case (byte_w[5:4])
              2'b00: begin out_sr <= {stat_in, {(DATA_W-8){1'b0}}}; last <= LAST_B;
                           is_data <= 1'b0; st <= S_READ; end
              2'b01: begin out_sr <= {mode_in, {(DATA_W-8){1'b0}}}; last <= LAST_B;
                           is_data <= 1'b0; st <= S_READ; end
              2'b11: begin
                if (byte_w[2]) st <= S_CREAD;
                else begin out_sr <= data_in; last <= LAST_D; is_data <= 1'b1; st <= S_READ; end
              end
              default: st <= S_CMD;
            endcase
          end else if (byte_w[5:4] == 2'b01) begin
            st <= S_WMODE;
          end
        end
        if (byte_done && st == S_CREAD && byte_w[5:2] == 4'b1110 && !drdy)
          st <= S_CMD;
        if (st == S_WMODE && rise) begin
          wsr <= {wsr[6:0], din_s};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_B) begin
            mode_wr <= 1'b1; mode_wdata <= {wsr[6:0], din_s};
            cnt <= '0; st <= S_CMD;
          end
        end
        if (st == S_CREAD && !active && fall && drdy) begin
          out_sr <= data_in; last <= LAST_D; is_data <= 1'b1;
          active <= 1'b1; cnt <= '0; wen_seen <= 1'b0; cbits <= '0;
        end
        if (st == S_READ && fall && !active) active <= 1'b1;
        if ((st == S_READ || st == S_CREAD) && active) begin
          if (fall) out_sr <= out_sr << 1;
          if (rise) begin
            if (cnt == last) begin
              active <= 1'b0; cnt <= '0; data_rd <= is_data;
              if (st == S_READ) st <= S_CMD;
            end else cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

module sd_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic dout_oe,
  input logic mode_wr,
  input logic data_rd,
  input logic dev_rst
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;

  AST_OE_TRACKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !$past(cs_n, 2) && !$past(cs_n, 3) && !$past(cs_n, 4)) |-> dout_oe); // R13
  AST_OE_OFF_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !dout_oe); // R13
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr && data_rd)); // R5
  AST_MODE_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !mode_wr); // R5
  AST_DATA_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> !data_rd); // R6
  AST_DEV_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> !dev_rst); // R9
  AST_QUIET_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5 && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4) && $past(cs_n, 5))
      |-> !(mode_wr || data_rd || dev_rst)); // R12
endmodule

bind sd_serial_port sd_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout_oe(dout_oe),
  .mode_wr(mode_wr), .data_rd(data_rd), .dev_rst(dev_rst)
);

// File: tb/sd_serial_port_tb.sv
module sd_serial_port_tb;
  localparam int DW   = 24;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, din = 1'b0, drdy = 1'b0;
  logic [7:0] stat_in = '0, mode_in = '0;
  logic [DW-1:0] data_in = '0;
  logic dout, dout_oe, mode_wr, data_rd, dev_rst;
  logic [7:0] mode_wdata;
  logic [1:0] chan;

  int checks = 0, errors = 0, n_wr = 0, n_rd = 0, n_rst = 0;
  logic [7:0] last_wr = '0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_serial_port #(.DATA_W(DW), .RESYNC_ONES(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .drdy(drdy), .stat_in(stat_in),
    .mode_in(mode_in), .data_in(data_in), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .data_rd(data_rd), .chan(chan), .dev_rst(dev_rst)
  );

  always @(posedge clk) begin
    if (mode_wr) begin n_wr <= n_wr + 1; last_wr <= mode_wdata; end
    if (data_rd) n_rd <= n_rd + 1;
    if (dev_rst) n_rst <= n_rst + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bitc(input logic b, output logic r);
    @(negedge clk); sclk = 1'b0; din = b;
    repeat (HALF) @(negedge clk);
    r = dout; sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [31:0] tx, output logic [31:0] rx);
    logic b;
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitc(tx[i], b);
      rx = {rx[30:0], b};
    end
    din = 1'b0;
  endtask

  task automatic sel(input logic v);
    @(negedge clk); cs_n = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] rd_cmd(input logic [1:0] rs, input logic [1:0] ch);
    return {2'b00, rs, 1'b1, 1'b0, ch};
  endfunction

  initial begin
    logic [31:0] rx;
    int b_wr, b_rd, b_rst;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe off", dout_oe, 0);
    chk("R1 chan", chan, 0);
    chk("R1 strobes", {mode_wr, data_rd, dev_rst}, 0);
    sel(1'b0);
    chk("R13 oe on", dout_oe, 1);
    chk("R1 idle pin not ready", dout, 1);
    drdy = 1'b1; repeat (3) @(negedge clk);
    chk("R1 idle pin ready", dout, 0);
    drdy = 1'b0;

    stat_in = 8'hA5;
    xfer(11, {3'b111, 8'h09}, rx);
    xfer(8, 0, rx);
    chk("R2 leading ones skipped", rx[7:0], 8'hA5);
    chk("R8 chan", chan, 2'b01);

    for (int it = 0; it < 20; it++) begin
      logic [1:0] ch;
      logic [7:0] wv;
      stat_in = 8'($urandom); mode_in = 8'($urandom); data_in = DW'($urandom);
      ch = 2'($urandom); wv = 8'($urandom);
      xfer(8, rd_cmd(2'b00, ch), rx); xfer(8, 0, rx);
      chk("R3 status", rx[7:0], stat_in);
      chk("R8 chan", chan, ch);
      xfer(8, rd_cmd(2'b01, ch), rx); xfer(8, 0, rx);
      chk("R4 mode", rx[7:0], mode_in);
      b_rd = n_rd; drdy = 1'b1;
      xfer(8, rd_cmd(2'b11, ch), rx); xfer(DW, 0, rx);
      repeat (2) @(negedge clk);
      chk("R6 data", rx[DW-1:0], data_in);
      chk("R6 strobe", n_rd, b_rd + 1);
      drdy = 1'b0;
      b_wr = n_wr;
      xfer(8, 8'h10, rx); xfer(8, {24'h0, wv}, rx);
      repeat (2) @(negedge clk);
      chk("R5 mode write count", n_wr, b_wr + 1);
      chk("R5 mode write value", last_wr, wv);
    end

    b_wr = n_wr; b_rd = n_rd; stat_in = 8'h3C;
    xfer(8, 8'h28, rx); xfer(8, 8'h20, rx); xfer(8, 8'h30, rx); xfer(8, 8'h00, rx);
    xfer(8, 8'h08, rx); xfer(8, 0, rx);
    chk("R7 ignored regs then status", rx[7:0], 8'h3C);
    chk("R7 no strobes", {n_wr - b_wr, n_rd - b_rd}, 0);

    mode_in = 8'h5A;
    xfer(8, 8'h08, rx); xfer(3, 0, rx);
    sel(1'b1); sel(1'b0);
    xfer(8, 8'h10, rx); xfer(4, 32'hF, rx);
    sel(1'b1); sel(1'b0);
    repeat (2) @(negedge clk);
    chk("R12 no write after abort", n_wr, b_wr);
    xfer(8, 8'h18, rx); xfer(8, 0, rx);
    chk("R12 command wait after abort", rx[7:0], 8'h5A);

    b_rst = n_rst;
    xfer(32, 32'hFFFF_FFFF, rx);
    repeat (2) @(negedge clk);
    chk("R9 resync in command wait", n_rst, b_rst + 1);
    chk("R9 chan cleared", chan, 0);

    b_rst = n_rst;
    xfer(20, 32'hFFFFF, rx);
    sel(1'b1); sel(1'b0);
    xfer(12, 32'hFFF, rx);
    repeat (2) @(negedge clk);
    chk("R9 run survives select", n_rst, b_rst + 1);

    xfer(8, 8'h3C, rx);
    for (int k = 0; k < 2; k++) begin
      data_in = DW'($urandom); b_rd = n_rd; drdy = 1'b1;
      xfer(DW, 0, rx);
      repeat (2) @(negedge clk);
      chk("R10 stream data", rx[DW-1:0], data_in);
      chk("R10 stream strobe", n_rd, b_rd + 1);
      drdy = 1'b0;
    end
    data_in = 24'hC3A501; drdy = 1'b1; b_rd = n_rd;
    xfer(DW, {8'h38, 16'h0}, rx);
    repeat (2) @(negedge clk);
    chk("R11 exit ignored when ready", rx[DW-1:0], 24'hC3A501);
    drdy = 1'b0;
    data_in = 24'h0F1E2D; drdy = 1'b1;
    xfer(DW, 0, rx);
    chk("R11 still streaming", rx[DW-1:0], 24'h0F1E2D);
    drdy = 1'b0;
    stat_in = 8'h77;
    xfer(8, 8'h08, rx); xfer(8, 0, rx);
    chk("R11 status ignored in stream mode", rx[7:0], 8'hFF);
    xfer(8, 8'h38, rx);
    xfer(8, 8'h08, rx); xfer(8, 0, rx);
    chk("R11 exit accepted when not ready", rx[7:0], 8'h77);

    xfer(8, 8'h3C, rx);
    b_rst = n_rst;
    xfer(32, 32'hFFFF_FFFF, rx);
    xfer(8, 8'h08, rx); xfer(8, 0, rx);
    chk("R9 resync leaves stream mode", rx[7:0], 8'h77);
    chk("R9 resync pulse in stream mode", n_rst, b_rst + 1);

    sel(1'b1);
    chk("R13 oe off again", dout_oe, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule